// File: doc/BRIEF.md
# Latched Parallel-to-Serial Converter

This block turns a parallel word into a serial bit stream through two storage stages. A capture register takes a snapshot of the parallel input word whenever a one-cycle capture strobe is seen. A shift chain of the same width sits behind it. A mode input selects what the chain does. In transfer mode the chain copies the capture register on every clock edge. In shift mode the chain moves one place per one-cycle shift strobe, and a serial input enters at the first stage. The last stage of the chain is always the serial data bit. A separate drive flag, the inverse of an active-low output enable, lets a top level build a tri-state pin from the two signals.

All state changes on the rising edge of one system clock. The strobes replace separate latch and shift clocks. The capture register can be refilled while shifting is in progress, so the next word is ready before the current one has gone out. The block has no valid/ready handshake and applies no back-pressure. It accepts a strobe on any cycle, and the sender paces the words with the strobes. The output enable only gates the drive flag. It never touches the stored state.

Top module: `latched_piso`

## Requirements
- R1: A synchronous active-high reset clears the capture register and every chain stage to 0, so the serial data bit reads 0 after reset.
- R2: A capture strobe stores `par_in` into the capture register on that clock edge, in either mode. Bit i of `par_in` is stored in capture bit i.
- R3: While `ser_mode` is 0 (transfer), chain stage i takes capture bit i on every clock edge. `shift_stb` and `ser_in` have no effect on the chain in this mode.
- R4: While `ser_mode` is 1 (shift), each edge with `shift_stb` high moves stage 0 to `ser_in` and stage i to the old stage i-1. The old last stage is dropped.
- R5: While `ser_mode` is 1 and neither strobe is high, the capture register and the chain both keep their contents.
- R6: A capture strobe while `ser_mode` is 0 loads the new word into both the capture register and the chain on the same edge. `par_in[WIDTH-1]` therefore appears on `ser_out` right after that edge.
- R7: While `ser_mode` is 1, a capture strobe and a shift strobe on the same edge both take effect. The chain shifts its old contents and does not take the newly captured word.
- R8: `ser_out` is always chain stage WIDTH-1. `ser_drive` equals the inverse of `oe_n` combinationally. `oe_n` has no effect on any stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | WIDTH | Parallel word offered to the capture register |
| cap_stb | input | 1 | One-cycle capture strobe |
| shift_stb | input | 1 | One-cycle shift strobe |
| ser_mode | input | 1 | 0 = transfer from the capture register, 1 = serial shift |
| ser_in | input | 1 | Serial data entering chain stage 0 |
| oe_n | input | 1 | Output enable, active low |
| ser_out | output | 1 | Serial data bit, chain stage WIDTH-1 |
| ser_drive | output | 1 | High when the pin should be driven |

## Verification
The bench builds the block with WIDTH = 8. At that width every possible parallel word (all 256 of them) can be loaded through and shifted fully out. This exposes every stage holding both polarities, and it catches any bit-order or stage-skip error. The capture register has no port of its own, so a later transfer brings it out to the serial data bit. Concurrent capture and shift, strobes ignored in transfer mode, and enable toggling are each placed in directed sequences. A long random run of mode, strobe and enable patterns follows, and each cycle is compared against an arithmetic model.

// File: rtl/piso_pkg.sv
`timescale 1ns/1ps
package piso_pkg;
  // Chain behaviour chosen by the mode input.
  typedef enum logic {
    MODE_XFER  = 1'b0,
    MODE_SHIFT = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/piso_capture_reg.sv
`timescale 1ns/1ps
module piso_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_stb,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] cap_q
);
  always_ff @(posedge clk) begin
    if (rst)          cap_q <= '0;
    else if (cap_stb) cap_q <= par_in;
  end

  // R2: a strobed word is held in the capture register on the next cycle
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    cap_stb |=> cap_q == $past(par_in));
  // R5: without a strobe the snapshot is kept
  a_r5_cap_hold: assert property (@(posedge clk) disable iff (rst)
    !cap_stb |=> $stable(cap_q));
endmodule

// File: rtl/piso_shift_chain.sv
`timescale 1ns/1ps
module piso_shift_chain
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_i,
  input  logic             shift_stb,
  input  logic             cap_stb,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  input  logic [WIDTH-1:0] cap_q,
  output logic [WIDTH-1:0] chain_q
);
  localparam int LAST = WIDTH - 1;

  xfer_mode_e      mode_e;
  logic [WIDTH-1:0] xfer_word;

  assign mode_e = xfer_mode_e'(mode_i);
  // Load-through: a capture in transfer mode feeds the fresh word straight in.
  assign xfer_word = cap_stb ? par_in : cap_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic shift_src;
    if (i == 0) begin : g_head
      assign shift_src = ser_in;
    end else begin : g_body
      assign shift_src = chain_q[i-1];
    end

    always_ff @(posedge clk) begin
      if (rst)                     chain_q[i] <= 1'b0;
      else if (mode_e == MODE_XFER) chain_q[i] <= xfer_word[i];
      else if (shift_stb)          chain_q[i] <= shift_src;
    end
  end

  // R3: transfer mode copies the capture register, strobes for shifting ignored
  a_r3_xfer: assert property (@(posedge clk) disable iff (rst)
    (!mode_i && !cap_stb) |=> chain_q == $past(cap_q));
  // R6: capture in transfer mode reaches the chain on the same edge
  a_r6_load_through: assert property (@(posedge clk) disable iff (rst)
    (!mode_i && cap_stb) |=> chain_q == $past(par_in));
  // R4/R7: a shift moves old contents, regardless of a concurrent capture
  a_r4_shift: assert property (@(posedge clk) disable iff (rst)
    (mode_i && shift_stb) |=> chain_q == {$past(chain_q[LAST-1:0]), $past(ser_in)});
  // R5: shift mode without a shift strobe holds the chain
  a_r5_chain_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_i && !shift_stb) |=> $stable(chain_q));
endmodule

// File: rtl/piso_out_stage.sv
`timescale 1ns/1ps
module piso_out_stage #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] chain_q,
  input  logic             oe_n,
  output logic             ser_out,
  output logic             ser_drive
);
  localparam int LAST = WIDTH - 1;
  assign ser_out   = chain_q[LAST];
  assign ser_drive = ~oe_n;
endmodule

// File: rtl/latched_piso.sv
`timescale 1ns/1ps
module latched_piso #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] par_in,
  input  logic             cap_stb,
  input  logic             shift_stb,
  input  logic             ser_mode,
  input  logic             ser_in,
  input  logic             oe_n,
  output logic             ser_out,
  output logic             ser_drive
);
  logic [WIDTH-1:0] cap_q;
  logic [WIDTH-1:0] chain_q;

  piso_capture_reg #(.WIDTH(WIDTH)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .cap_stb (cap_stb),
    .par_in  (par_in),
    .cap_q   (cap_q)
  );

  piso_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (ser_mode),
    .shift_stb (shift_stb),
    .cap_stb   (cap_stb),
    .ser_in    (ser_in),
    .par_in    (par_in),
    .cap_q     (cap_q),
    .chain_q   (chain_q)
  );

  piso_out_stage #(.WIDTH(WIDTH)) u_out (
    .chain_q   (chain_q),
    .oe_n      (oe_n),
    .ser_out   (ser_out),
    .ser_drive (ser_drive)
  );

  // R1: the cycle after reset the serial bit is cleared
  a_r1_reset_out: assert property (@(posedge clk)
    rst |=> !ser_out);
  // R8: the output bit only moves on a clock edge where the chain may update
  a_r8_out_stable: assert property (@(posedge clk) disable iff (rst)
    (ser_mode && !shift_stb) |=> $stable(ser_out));
endmodule

// File: tb/test_latched_piso.sv
`timescale 1ns/1ps
module test_latched_piso;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] par_in = '0;
  logic         cap_stb = 1'b0, shift_stb = 1'b0, ser_mode = 1'b1;
  logic         ser_in = 1'b0, oe_n = 1'b1;
  logic         ser_out, ser_drive;

  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] m_cap = '0;
  logic [W-1:0] m_chain = '0;

  latched_piso #(.WIDTH(W)) i_latched_piso (
    .clk(clk), .rst(rst), .par_in(par_in), .cap_stb(cap_stb),
    .shift_stb(shift_stb), .ser_mode(ser_mode), .ser_in(ser_in),
    .oe_n(oe_n), .ser_out(ser_out), .ser_drive(ser_drive)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle from a falling edge, advance the model, check after the edge.
  task automatic cyc(input logic cap, input logic sh, input logic md,
                     input logic si, input logic [W-1:0] pw, input logic oen,
                     input string tag);
    logic [W-1:0] nx_cap, nx_chain;
    cap_stb = cap; shift_stb = sh; ser_mode = md; ser_in = si;
    par_in = pw; oe_n = oen;
    #1 chk("R8 drive", ser_drive, ~oen);
    nx_cap = cap ? pw : m_cap;
    if (!md)     nx_chain = cap ? pw : m_cap;
    else if (sh) nx_chain = {m_chain[W-2:0], si};
    else         nx_chain = m_chain;
    m_cap = nx_cap; m_chain = nx_chain;
    @(posedge clk); @(negedge clk);
    chk(tag, ser_out, m_chain[W-1]);
    chk("R8 drive", ser_drive, ~oen);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset", ser_out, 1'b0);
    // R1: transfer of the cleared capture register keeps zero
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, "R1 cleared capture");

    // R6/R4: every word loaded through, then shifted fully out
    for (int w = 0; w < 256; w++) begin
      cyc(1'b1, 1'b0, 1'b0, 1'b0, w[W-1:0], w[0], "R6 load through");
      chk("R6 msb", ser_out, w[W-1]);
      for (int k = 1; k < W; k++) begin
        cyc(1'b0, 1'b1, 1'b1, k[0], 8'h00, k[1], "R4 shift");
        chk("R4 bit order", ser_out, w[W-1-k]);
      end
    end

    // R3: shift strobes and serial data ignored in transfer mode
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b0, "R2 capture in shift mode");
    for (int k = 0; k < 4; k++)
      cyc(1'b0, 1'b1, 1'b0, k[0], 8'h00, 1'b0, "R3 ignore shift");
    chk("R3 xfer msb", ser_out, 1'b1);
    // R5: hold then shift out whole captured word
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 1'b1, "R5 hold");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, "R5 hold");
    for (int k = 1; k < W; k++) begin
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R3 chain intact");
      chk("R3 word bits", ser_out, 8'hA5 >> (W-1-k));
    end

    // R7: concurrent capture and shift
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0, "R6 preload");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 8'hC3, 1'b0, "R7 both strobes");
    chk("R7 old data shifted", ser_out, 8'h3C >> (W-2));
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R7 latch took new word");
    chk("R7 new word msb", ser_out, 1'b1);

    // R8: enable toggles leave state alone
    for (int k = 0; k < 6; k++)
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, k[0], "R8 oe no effect");
    chk("R8 state kept", ser_out, 1'b1);

    // Random mixed traffic against the model
    for (int t = 0; t < 6000; t++) begin
      int unsigned r;
      r = $urandom;
      cyc(r[0] & r[1], r[2], r[3] | r[4], r[5], r[13:6], r[14], "R4 random");
    end

    // R1: reset mid-stream
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_cap = '0; m_chain = '0;
    chk("R1 reset again", ser_out, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, "R1 capture cleared");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule